// File: doc/BRIEF.md
# Stuck-At Test Vector Sequencer for a Two-Level Carry-Skip Adder

This block steps through a fixed list of stimulus vectors that together detect every single stuck-at fault in an N_BITS-wide adder. That adder groups its stages into blocks of BLK stages and groups its blocks into superblocks of SUPER blocks, with skip logic at both levels. Each vector drives both operands, the adder carry-in and the extra gating input that the testable version of the skip logic needs. The list is built from three kinds of pattern. Some patterns are the same in every stage. Some alternate between even and odd stage pairs. The rest are placed by block or by superblock, with the parity of the block or superblock deciding the pattern. The block does not count through operand values and does not use a pseudo-random source.

A pulse on `start` starts a pass. The block presents one vector at a time with `valid` and moves to the next vector when `ready` is also high. After the last vector is accepted it raises `done` and holds it there until the next pass. The number of vectors depends only on BLK and SUPER. The word width does not change it, so a wider adder needs no longer test. N_BITS must be a multiple of BLK*SUPER.

Top module: `ctsg_gen`

## Requirements
- R1: While reset is low, and whenever no vector is offered, `valid` is 0 and `op_a`, `op_b`, `carry_in` and `test_en` are all 0. While reset is low, `done` is also 0.
- R2: A `start` pulse in the idle or finished state makes vector 0 appear on the next clock edge. Vector 0 has every stage at A=0, B=0, with `carry_in`=0 and `test_en`=1.
- R3: Vectors 1 to 3 put every stage at A=0, B=1. The carry_in/test_en pairs are 0/1, then 1/1, then 1/0. Vectors 4 to 6 repeat this with every stage at A=1, B=0.
- R4: Vector 7 puts every stage at A=B=1, with carry_in 0 and test_en 1. Vector 8 puts stage pairs at (1,1) on even stage indices and (0,1) on odd ones, with carry_in 0 and test_en 1. Vector 9 puts (1,0) on even stages and (1,1) on odd ones, with carry_in 1 and test_en 1.
- R5: Vector 10 has carry_in 1 and test_en 0. The first block of every superblock is all A=B=0, and every other block is all A=B=1.
- R6: Vectors 11+2j and 12+2j are block vectors, for j from 0 to BLK-1, with carry_in 1 and test_en 1. Stage j of every block is (0,0). The last stage of each block is (1,1) when that block's index is even (first vector) or odd (second vector). Block indices count from 0. Every other stage is (0,1). The zero stage takes priority.
- R7: The final 2*SUPER vectors are superblock vectors, for k from 0 to SUPER-1, with carry_in 1 and test_en 1. Block k of every superblock is all (0,0). The last block of each superblock is all (1,1) when the superblock index is even (first vector) or odd (second vector). Every other stage is (0,1). The zero block takes priority.
- R8: A pass has exactly 11+2*BLK+2*SUPER vectors. The count and the handshake timing do not depend on N_BITS.
- R9: While `valid` is high and `ready` is low, the vector is held unchanged. Each accepted handshake moves the sequence on by exactly one vector.
- R10: After the last vector is accepted, `valid` falls and `done` rises on the same edge. `done` stays high until a new `start`, which restarts the sequence from vector 0.
- R11: A `start` pulse during a pass has no effect on the vector shown or on the order of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass when idle or finished |
| ready | input | 1 | Consumer accepts the offered vector |
| op_a | output | N_BITS | Operand A of the current vector |
| op_b | output | N_BITS | Operand B of the current vector |
| carry_in | output | 1 | Adder carry-in of the current vector |
| test_en | output | 1 | Skip-logic gating input of the current vector |
| valid | output | 1 | A vector is offered |
| done | output | 1 | The pass is complete |

## Verification
The bench targets the positions where a sequencer is most likely to go wrong. These are the zero-over-ones priority when the chosen stage or block is also the last one, the even/odd swap between the two vectors of each pair, and the boundaries between the fixed, block and superblock parts of the list. A design that mixed up parity or priority would emit a wrong bit in one stage of one vector, and the per-vector comparison would catch it. Stalls of uneven length check that a design which advanced on `valid` alone would skip vectors. A `start` pulse in the middle of a pass checks that a design which restarted on it would repeat vector 0. A second, twice-as-wide instance runs in lock step with the first. Its low half must match the first instance, and its handshake must match cycle for cycle, which would expose any length that depended on the word width.

// File: rtl/ctsg_pkg.sv
package ctsg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } ctsg_state_e;

  typedef enum logic [1:0] {
    PH_FIXED,
    PH_BLOCK,
    PH_SUPER
  } ctsg_phase_e;

  localparam int unsigned FIXED_CNT = 11;

  function automatic int unsigned total_vectors(input int unsigned blk, input int unsigned sup);
    return FIXED_CNT + 2 * blk + 2 * sup;
  endfunction

  // carry-in of the uniform vectors 0..10
  function automatic logic fixed_cin(input logic [3:0] code);
    case (code)
      4'd0, 4'd1, 4'd4, 4'd7, 4'd8: return 1'b0;
      default:                      return 1'b1;
    endcase
  endfunction

  // gating input of the uniform vectors 0..10
  function automatic logic fixed_test(input logic [3:0] code);
    case (code)
      4'd3, 4'd6, 4'd10: return 1'b0;
      default:           return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ctsg_step_ctrl.sv
module ctsg_step_ctrl
  import ctsg_pkg::*;
#(
  parameter int unsigned TOTAL  = 19,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ready,
  output logic [STEP_W-1:0] step,
  output logic              offer,
  output logic              finished,
  output logic              accept,
  output logic              last_accept
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(TOTAL - 1);

  ctsg_state_e state;

  assign offer       = (state == ST_RUN);
  assign finished    = (state == ST_DONE);
  assign accept      = offer && ready;
  assign last_accept = accept && (step == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_RUN;
            step  <= '0;
          end
        end
        ST_RUN: begin
          if (accept) begin
            if (step == LAST) state <= ST_DONE;
            else              step  <= step + STEP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctsg_step_decode.sv
module ctsg_step_decode
  import ctsg_pkg::*;
#(
  parameter int unsigned BLK    = 2,
  parameter int unsigned STEP_W = 5,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [STEP_W-1:0] step,
  output ctsg_phase_e       phase,
  output logic [3:0]        code,
  output logic [SEL_W-1:0]  sel,
  output logic              swap,
  output logic              cin,
  output logic              tst
);

  localparam int unsigned BLK_END = FIXED_CNT + 2 * BLK;

  int unsigned s;
  int unsigned rel;

  always_comb begin
    s     = 32'(step);
    rel   = 0;
    phase = PH_FIXED;
    code  = '0;
    sel   = '0;
    swap  = 1'b0;
    cin   = 1'b1;
    tst   = 1'b1;
    if (s < FIXED_CNT) begin
      code = 4'(s);
      cin  = fixed_cin(4'(s));
      tst  = fixed_test(4'(s));
    end else if (s < BLK_END) begin
      rel   = s - FIXED_CNT;
      phase = PH_BLOCK;
      sel   = SEL_W'(rel >> 1);
      swap  = rel[0];
    end else begin
      rel   = s - BLK_END;
      phase = PH_SUPER;
      sel   = SEL_W'(rel >> 1);
      swap  = rel[0];
    end
  end

endmodule

// File: rtl/ctsg_stage_pat.sv
module ctsg_stage_pat
  import ctsg_pkg::*;
#(
  parameter int unsigned N_BITS = 16,
  parameter int unsigned BLK    = 2,
  parameter int unsigned SUPER  = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  ctsg_phase_e      phase,
  input  logic [3:0]       code,
  input  logic [SEL_W-1:0] sel,
  input  logic             swap,
  output logic [N_BITS-1:0] a,
  output logic [N_BITS-1:0] b
);

  for (genvar s = 0; s < N_BITS; s++) begin : g_stage
    localparam int unsigned POS  = s % BLK;
    localparam int unsigned BIDX = s / BLK;
    localparam int unsigned BIB  = BIDX % SUPER;
    localparam int unsigned SBI  = BIDX / SUPER;
    localparam bit EVEN_S   = (s % 2) == 0;
    localparam bit LAST_POS = (POS == BLK - 1);
    localparam bit EVEN_BLK = (BIDX % 2) == 0;
    localparam bit LAST_BIB = (BIB == SUPER - 1);
    localparam bit EVEN_SB  = (SBI % 2) == 0;

    logic [1:0] ab;

    always_comb begin
      ab = 2'b00;
      case (phase)
        PH_FIXED: begin
          case (code)
            4'd1, 4'd2, 4'd3: ab = 2'b01;
            4'd4, 4'd5, 4'd6: ab = 2'b10;
            4'd7:             ab = 2'b11;
            4'd8:             ab = EVEN_S ? 2'b11 : 2'b01;
            4'd9:             ab = EVEN_S ? 2'b10 : 2'b11;
            4'd10:            ab = (BIB == 0) ? 2'b00 : 2'b11;
            default:          ab = 2'b00;
          endcase
        end
        PH_BLOCK: begin
          if (sel == SEL_W'(POS))                 ab = 2'b00;
          else if (LAST_POS && (EVEN_BLK ^ swap)) ab = 2'b11;
          else                                    ab = 2'b01;
        end
        PH_SUPER: begin
          if (sel == SEL_W'(BIB))                ab = 2'b00;
          else if (LAST_BIB && (EVEN_SB ^ swap)) ab = 2'b11;
          else                                   ab = 2'b01;
        end
        default: ab = 2'b00;
      endcase
    end

    assign a[s] = ab[1];
    assign b[s] = ab[0];
  end

endmodule

// File: rtl/ctsg_gen.sv
module ctsg_gen
  import ctsg_pkg::*;
#(
  parameter int unsigned N_BITS = 16,
  parameter int unsigned BLK    = 2,
  parameter int unsigned SUPER  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ready,
  output logic [N_BITS-1:0] op_a,
  output logic [N_BITS-1:0] op_b,
  output logic              carry_in,
  output logic              test_en,
  output logic              valid,
  output logic              done
);

  localparam int unsigned TOTAL  = total_vectors(BLK, SUPER);
  localparam int unsigned STEP_W = $clog2(TOTAL);
  localparam int unsigned SEL_MX = (BLK > SUPER) ? BLK : SUPER;
  localparam int unsigned SEL_W  = $clog2(SEL_MX) + 1;

  logic [STEP_W-1:0] step;
  logic              offer;
  logic              accept;
  logic              last_accept;
  ctsg_phase_e       phase;
  logic [3:0]        code;
  logic [SEL_W-1:0]  sel;
  logic              swap;
  logic              cin_raw;
  logic              tst_raw;
  logic [N_BITS-1:0] a_raw;
  logic [N_BITS-1:0] b_raw;

  ctsg_step_ctrl #(.TOTAL(TOTAL), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .step(step), .offer(offer), .finished(done),
    .accept(accept), .last_accept(last_accept)
  );

  ctsg_step_decode #(.BLK(BLK), .STEP_W(STEP_W), .SEL_W(SEL_W)) u_dec (
    .step(step), .phase(phase), .code(code), .sel(sel),
    .swap(swap), .cin(cin_raw), .tst(tst_raw)
  );

  ctsg_stage_pat #(.N_BITS(N_BITS), .BLK(BLK), .SUPER(SUPER), .SEL_W(SEL_W)) u_pat (
    .phase(phase), .code(code), .sel(sel), .swap(swap),
    .a(a_raw), .b(b_raw)
  );

  assign valid    = offer;
  assign op_a     = offer ? a_raw : '0;
  assign op_b     = offer ? b_raw : '0;
  assign carry_in = offer && cin_raw;
  assign test_en  = offer && tst_raw;

endmodule

// File: rtl/ctsg_gen_chk.sv
module ctsg_gen_chk #(
  parameter int unsigned N_BITS = 16,
  parameter int unsigned BLK    = 2,
  parameter int unsigned SUPER  = 2,
  parameter int unsigned STEP_W = 5,
  parameter int unsigned TOTAL  = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic [N_BITS-1:0] op_a,
  input logic [N_BITS-1:0] op_b,
  input logic              carry_in,
  input logic              test_en,
  input logic              valid,
  input logic              done,
  input logic [STEP_W-1:0] step,
  input logic              accept,
  input logic              last_accept
);

  initial AST_WIDTH_MULTIPLE: assert (N_BITS % (BLK * SUPER) == 0); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!valid && !done)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (op_a == '0 && op_b == '0 && !carry_in && !test_en)); // R1

  AST_FIRST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (op_a == '0 && op_b == '0 && !carry_in && test_en)); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(op_a) && $stable(op_b)
                           && $stable(carry_in) && $stable(test_en))); // R9

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_accept) |=> (valid && step == $past(step) + STEP_W'(1))); // R9

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(step) < TOTAL); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> (done && !valid)); // R10

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && start && !ready) |=> (valid && $stable(step))); // R11

endmodule

bind ctsg_gen ctsg_gen_chk #(
  .N_BITS(N_BITS), .BLK(BLK), .SUPER(SUPER), .STEP_W(STEP_W), .TOTAL(TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .test_en(test_en),
  .valid(valid), .done(done), .step(step), .accept(accept),
  .last_accept(last_accept)
);

// File: tb/ctsg_gen_tb.sv
`timescale 1ns/1ps
module ctsg_gen_tb;

  localparam int W    = 16;
  localparam int W2   = 32;
  localparam int BS   = 2;
  localparam int SB   = 2;
  localparam int NVEC = 11 + 2 * BS + 2 * SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready = 1'b0;
  logic [W-1:0]  op_a, op_b;
  logic          carry_in, test_en, valid, done;
  logic [W2-1:0] wa, wb;
  logic          wcin, wtst, wvalid, wdone;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ctsg_gen #(.N_BITS(W), .BLK(BS), .SUPER(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .test_en(test_en),
    .valid(valid), .done(done)
  );

  ctsg_gen #(.N_BITS(W2), .BLK(BS), .SUPER(SB)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .op_a(wa), .op_b(wb), .carry_in(wcin), .test_en(wtst),
    .valid(wvalid), .done(wdone)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int idx);
    if (idx == 0)                return "R2";
    if (idx <= 6)                return "R3";
    if (idx <= 9)                return "R4";
    if (idx == 10)               return "R5";
    if (idx < 11 + 2 * BS)       return "R6";
    return "R7";
  endfunction

  // expected vector, built stage-group by stage-group from the requirements
  task automatic ref_vec(input int idx, output logic [W-1:0] ra, output logic [W-1:0] rb,
                         output logic rc, output logic rt);
    int nblk;
    int nsb;
    int j;
    int sw;
    nblk = W / BS;
    nsb  = nblk / SB;
    ra = '0; rb = '0; rc = 1'b1; rt = 1'b1;
    case (idx)
      0: rc = 1'b0;
      1: begin rb = '1; rc = 1'b0; end
      2: rb = '1;
      3: begin rb = '1; rt = 1'b0; end
      4: begin ra = '1; rc = 1'b0; end
      5: ra = '1;
      6: begin ra = '1; rt = 1'b0; end
      7: begin ra = '1; rb = '1; rc = 1'b0; end
      8: begin
        rb = '1; rc = 1'b0;
        for (int i = 0; i < W; i += 2) ra[i] = 1'b1;
      end
      9: begin
        ra = '1;
        for (int i = 1; i < W; i += 2) rb[i] = 1'b1;
      end
      10: begin
        rt = 1'b0;
        for (int bl = 0; bl < nblk; bl++)
          if (bl % SB != 0)
            for (int p = 0; p < BS; p++) begin ra[bl*BS+p] = 1'b1; rb[bl*BS+p] = 1'b1; end
      end
      default: begin
        rb = '1;
        if (idx < 11 + 2 * BS) begin
          j  = (idx - 11) / 2;
          sw = (idx - 11) % 2;
          for (int bl = 0; bl < nblk; bl++)
            if (bl % 2 == sw) ra[bl*BS+BS-1] = 1'b1;
          for (int bl = 0; bl < nblk; bl++) begin
            ra[bl*BS+j] = 1'b0; rb[bl*BS+j] = 1'b0;
          end
        end else begin
          j  = (idx - 11 - 2 * BS) / 2;
          sw = (idx - 11 - 2 * BS) % 2;
          for (int s = 0; s < nsb; s++)
            if (s % 2 == sw)
              for (int p = 0; p < BS; p++) ra[(s*SB+SB-1)*BS+p] = 1'b1;
          for (int s = 0; s < nsb; s++)
            for (int p = 0; p < BS; p++) begin
              ra[(s*SB+j)*BS+p] = 1'b0; rb[(s*SB+j)*BS+p] = 1'b0;
            end
        end
      end
    endcase
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!valid && !done, "R1", {62'd0, valid, done}, 64'd0);
    check(op_a == '0 && op_b == '0 && !carry_in && !test_en, "R1",
          {30'd0, op_a, op_b, carry_in, test_en}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid && !done, "R1", {62'd0, valid, done}, 64'd0);
  endtask

  // mode 0: ready always high; 1: every other cycle; 2: one in three;
  // 3: ready high except a stall with start pulsed at vector 5
  task automatic t_pass(input int mode);
    logic [W-1:0] ea, eb;
    logic ec, et;
    int idx;
    int cyc;
    bit stalled_start;
    bit rdy;
    idx = 0; cyc = 0; stalled_start = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (valid && cyc < 500) begin
      case (mode)
        1: rdy = (cyc % 2 == 1);
        2: rdy = (cyc % 3 == 2);
        default: rdy = 1'b1;
      endcase
      if (mode == 3 && idx == 5 && !stalled_start) begin
        rdy = 1'b0; start = 1'b1; stalled_start = 1;
      end else start = 1'b0;
      ready = rdy;
      ref_vec(idx, ea, eb, ec, et);
      check(op_a == ea && op_b == eb && carry_in == ec && test_en == et,
            (mode == 3 && idx == 5) ? "R11" : req_of(idx),
            {30'd0, op_a, op_b, carry_in, test_en}, {30'd0, ea, eb, ec, et});
      check(wvalid == valid && wa[W-1:0] == op_a && wb[W-1:0] == op_b
            && wcin == carry_in && wtst == test_en, "R8",
            {31'd0, wvalid, wa}, {31'd0, valid, 16'd0, op_a});
      if (rdy) idx++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    ready = 1'b0;
    check(idx == NVEC, "R8", 64'(idx), 64'(NVEC));
    check(done && !valid && wdone, "R10", {61'd0, done, valid, wdone}, 64'd5);
    check(op_a == '0 && !test_en, "R1", {47'd0, op_a, test_en}, 64'd0);
    repeat (3) @(negedge clk);
    check(done && !valid, "R10", {62'd0, done, valid}, 64'd2);
  endtask

  task automatic t_stall_hold();
    logic [W-1:0] ea, eb;
    logic ec, et;
    ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    ref_vec(0, ea, eb, ec, et);
    check(valid && op_a == ea && op_b == eb && et, "R9", {62'd0, valid, test_en}, 64'd3);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    repeat (2) @(negedge clk);
    ref_vec(1, ea, eb, ec, et);
    check(valid && op_b == eb && op_a == ea && carry_in == ec, "R9",
          {31'd0, valid, op_a, op_b}, {31'd0, 1'b1, ea, eb});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !done, "R1", {62'd0, valid, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass(0);
    t_pass(1);
    t_pass(2);
    t_pass(3);
    t_stall_hold();
    t_pass(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule